// File: doc/BRIEF.md
# Hyperbolic Sine, Cosine and Exponential Pipeline

This block takes a signed fixed-point number x and returns cosh(x), sinh(x) and e^x as signed fixed-point words. The magnitude of x is split at its binary point. The whole-number part selects a pair of precomputed values, cosh(n) and sinh(n), from a small table. The leftover fraction f, which lies in [0, 1), runs through a pipelined shift-and-add rotator in hyperbolic mode. The rotator starts with y = 0 and with x preloaded by the reciprocal of its own gain, so it yields cosh(f) and sinh(f) with no scale factor. The two pairs are then merged with the addition identities for hyperbolic functions. The sign of x is restored last: sinh is odd and cosh is even.

The exponential is formed as the sum of the two signed results. A parameter sets the largest whole-number part the table covers, because the outputs grow very quickly with it. An input beyond that range raises an overflow flag and produces saturated outputs. Samples stream in and out through valid/ready handshakes. One sample is accepted per cycle while the output side keeps up. A stall at the output freezes the whole pipeline.

Top module: `hyp_sinhcosh_exp`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: For an input whose whole-number part |x| >> IN_FRAC is at most INT_MAX, out_cosh (OUT_FRAC fraction bits, default 16) equals cosh(x) to within 1e-3 of cosh(x) plus 16 LSB. It is also strictly greater than |out_sinh|.
- R3: Under the same condition, out_sinh equals sinh(x) within the same bound, and its sign follows the sign of x.
- R4: For a nonzero x, the result for -x has out_cosh bit-identical to the result for x and out_sinh equal to its exact two's-complement negation.
- R5: When out_ovf is 0, out_exp equals out_cosh + out_sinh exactly. It equals e^x within the bound of R2.
- R6: When the whole-number part of |x| exceeds INT_MAX, out_ovf is 1 and the outputs saturate. out_cosh is 2^(OUT_W-1)-1. out_sinh is plus or minus that value, following the sign of x. out_exp is that value for positive x and 0 for negative x. The most negative input code is included in this case.
- R7: A whole-number part equal to INT_MAX (inputs 4.0 up to 4.999 at default settings) is in range and gives out_ovf = 0. The first code past that range (5.0) gives out_ovf = 1.
- R8: in_ready equals (not out_valid) or out_ready. While out_valid is 1 and out_ready is 0, all outputs hold steady. Results leave in the order their inputs were accepted, one per accepted input.
- R9: With out_ready held at 1, a sample accepted on one rising edge appears on the outputs right after the ITERS+3-th rising edge that follows. That is 19 edges at default settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_x | input | IN_W | Signed input, IN_FRAC fraction bits |
| out_valid | output | 1 | Result words are valid |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_cosh | output | OUT_W | Signed cosh(x), OUT_FRAC fraction bits |
| out_sinh | output | OUT_W | Signed sinh(x), OUT_FRAC fraction bits |
| out_exp | output | OUT_W | Signed e^x, OUT_FRAC fraction bits (0 when EXP_EN is 0) |
| out_ovf | output | 1 | Whole-number part of |x| exceeded INT_MAX |

## Verification
The main stimulus is a sweep over the whole input code space with a stride of five, sent in mirrored pairs x, -x. The arithmetic checks on this sweep separate errors in the table from errors in the rotator, because every whole-number part is paired with many fractions. The mirrored pairs expose any sign or reflection fault as a bit-level mismatch between the two halves of a pair. Hand-picked codes sit on both sides of the table limit and at the extremes of the code range, which checks where the overflow edge falls and the saturation values. The output is throttled on a fixed pattern to exercise the stall path and ordering, and one isolated sample at full throughput pins down the pipeline depth.

// File: rtl/hyp_pkg.sv
package hyp_pkg;

  // Shift amount of rotator step k: 1,2,3,4,4,5,...,13,13,14,...
  function automatic int shift_of(input int k);
    int s;
    s = k + 1;
    if (k >= 4) s = k;
    if (k >= 14) s = k - 1;
    return s;
  endfunction

  // atanh by its odd power series (argument at most 0.5)
  function automatic real atanh_r(input real t);
    real acc;
    real p;
    acc = 0.0;
    p = t;
    for (int j = 0; j < 14; j++) begin
      acc += p / real'(2 * j + 1);
      p = p * t * t;
    end
    return acc;
  endfunction

  // Reciprocal of the accumulated hyperbolic gain over n steps
  function automatic real inv_gain(input int n);
    real g;
    g = 1.0;
    for (int k = 0; k < n; k++)
      g = g * $sqrt(1.0 - 2.0 ** (-2 * shift_of(k)));
    return 1.0 / g;
  endfunction

  function automatic longint to_fix(input real v, input int fb);
    return longint'(v * (2.0 ** fb));
  endfunction

endpackage

// File: rtl/hyp_reduce.sv
module hyp_reduce #(
  parameter int IN_W    = 16,
  parameter int IN_FRAC = 10,
  parameter int INT_MAX = 4,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      in_vld,
  input  logic signed [IN_W-1:0]    in_x,
  output logic                      vld_q,
  output logic                      neg_q,
  output logic                      ovf_q,
  output logic [IDX_W-1:0]          idx_q,
  output logic [IN_FRAC-1:0]        frac_q
);
  localparam int INT_W = IN_W - IN_FRAC + 1;

  logic signed [IN_W:0] ext;
  logic [IN_W:0]        mag;
  logic [INT_W-1:0]     ipart;
  logic                 over;

  always_comb begin
    ext   = {in_x[IN_W-1], in_x};
    mag   = ext[IN_W] ? $unsigned(-ext) : $unsigned(ext);
    ipart = mag[IN_W:IN_FRAC];
    over  = ipart > INT_W'(INT_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      neg_q  <= 1'b0;
      ovf_q  <= 1'b0;
      idx_q  <= '0;
      frac_q <= '0;
    end else if (en) begin
      vld_q  <= in_vld;
      neg_q  <= in_x[IN_W-1];
      ovf_q  <= over;
      idx_q  <= over ? '0 : ipart[IDX_W-1:0];
      frac_q <= mag[IN_FRAC-1:0];
    end
  end

  // R7: an in-range sample never addresses beyond the table
  p_idx_in_table_r7: assert property (@(posedge clk) disable iff (rst)
    vld_q && !ovf_q |-> int'(idx_q) <= INT_MAX);

endmodule

// File: rtl/hyp_cordic_stage.sv
module hyp_cordic_stage #(
  parameter int W     = 26,
  parameter int FB    = 22,
  parameter int STEP  = 0,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 in_vld,
  input  logic                 in_neg,
  input  logic                 in_ovf,
  input  logic [IDX_W-1:0]     in_idx,
  input  logic signed [W-1:0]  x_i,
  input  logic signed [W-1:0]  y_i,
  input  logic signed [W-1:0]  z_i,
  output logic                 vld_q,
  output logic                 neg_q,
  output logic                 ovf_q,
  output logic [IDX_W-1:0]     idx_q,
  output logic signed [W-1:0]  x_q,
  output logic signed [W-1:0]  y_q,
  output logic signed [W-1:0]  z_q
);
  localparam int S = hyp_pkg::shift_of(STEP);
  localparam logic signed [W-1:0] ANG =
    W'(hyp_pkg::to_fix(hyp_pkg::atanh_r(2.0 ** (-S)), FB));

  logic                up;
  logic signed [W-1:0] xs;
  logic signed [W-1:0] ys;

  always_comb begin
    up = !z_i[W-1];
    xs = x_i >>> S;
    ys = y_i >>> S;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (en) begin
      vld_q <= in_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      neg_q <= in_neg;
      ovf_q <= in_ovf;
      idx_q <= in_idx;
      x_q   <= up ? x_i + ys : x_i - ys;
      y_q   <= up ? y_i + xs : y_i - xs;
      z_q   <= up ? z_i - ANG : z_i + ANG;
    end
  end

endmodule

// File: rtl/hyp_int_rom.sv
module hyp_int_rom #(
  parameter int DEPTH = 5,
  parameter int W     = 28,
  parameter int FB    = 16,
  parameter int AW    = 3
) (
  input  logic                clk,
  input  logic                en,
  input  logic [AW-1:0]       addr,
  output logic signed [W-1:0] ch_q,
  output logic signed [W-1:0] sh_q
);
  localparam real EB = 2.718281828459045;

  logic signed [W-1:0] ch_tab [DEPTH];
  logic signed [W-1:0] sh_tab [DEPTH];

  for (genvar n = 0; n < DEPTH; n++) begin : g_tab
    localparam real GP = EB ** n;
    localparam real GN = 1.0 / GP;
    assign ch_tab[n] = W'(hyp_pkg::to_fix((GP + GN) / 2.0, FB));
    assign sh_tab[n] = W'(hyp_pkg::to_fix((GP - GN) / 2.0, FB));
  end

  // Registered read so the table maps onto a synchronous memory
  always_ff @(posedge clk) begin
    if (en) begin
      ch_q <= ch_tab[addr];
      sh_q <= sh_tab[addr];
    end
  end

endmodule

// File: rtl/hyp_combine.sv
module hyp_combine #(
  parameter int OUT_W  = 28,
  parameter int CW     = 26,
  parameter int CF     = 22,
  parameter int EXP_EN = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    in_vld,
  input  logic                    in_neg,
  input  logic                    in_ovf,
  input  logic signed [OUT_W-1:0] rc,
  input  logic signed [OUT_W-1:0] rs,
  input  logic signed [CW-1:0]    cc,
  input  logic signed [CW-1:0]    cs,
  output logic                    out_vld,
  output logic                    out_ovf,
  output logic signed [OUT_W-1:0] out_cosh,
  output logic signed [OUT_W-1:0] out_sinh,
  output logic signed [OUT_W-1:0] out_exp
);
  localparam int PW = OUT_W + CW + 1;
  localparam logic signed [PW-1:0] RND = PW'(longint'(1) << (CF - 1));
  localparam logic signed [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};

  logic signed [PW-1:0]    pc;
  logic signed [PW-1:0]    ps;
  logic signed [PW-1:0]    pc_sh;
  logic signed [PW-1:0]    ps_sh;
  logic                    a_vld;
  logic                    a_neg;
  logic                    a_ovf;
  logic signed [OUT_W-1:0] a_ch;
  logic signed [OUT_W-1:0] a_sh;
  logic signed [OUT_W-1:0] ch_n;
  logic signed [OUT_W-1:0] sh_n;
  logic signed [OUT_W-1:0] ex_n;
  logic signed [OUT_W-1:0] ex_sel;

  // Addition identities: table part times rotator part
  always_comb begin
    pc    = PW'(rc) * PW'(cc) + PW'(rs) * PW'(cs) + RND;
    ps    = PW'(rc) * PW'(cs) + PW'(rs) * PW'(cc) + RND;
    pc_sh = pc >>> CF;
    ps_sh = ps >>> CF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld <= 1'b0;
    end else if (en) begin
      a_vld <= in_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      a_neg <= in_neg;
      a_ovf <= in_ovf;
      a_ch  <= OUT_W'(pc_sh);
      a_sh  <= OUT_W'(ps_sh);
    end
  end

  // Sign restoration and saturation
  always_comb begin
    if (a_ovf) begin
      ch_n = MAXV;
      sh_n = a_neg ? -MAXV : MAXV;
      ex_n = a_neg ? '0 : MAXV;
    end else begin
      ch_n = a_ch;
      sh_n = a_neg ? -a_sh : a_sh;
      ex_n = a_neg ? a_ch - a_sh : a_ch + a_sh;
    end
  end

  if (EXP_EN != 0) begin : g_exp
    assign ex_sel = ex_n;
  end else begin : g_noexp
    assign ex_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_ovf  <= 1'b0;
      out_cosh <= '0;
      out_sinh <= '0;
      out_exp  <= '0;
    end else if (en) begin
      out_vld  <= a_vld;
      out_ovf  <= a_ovf;
      out_cosh <= ch_n;
      out_sinh <= sh_n;
      out_exp  <= ex_sel;
    end
  end

  // R2: cosh dominates |sinh| for every in-range result
  p_cosh_dominates_r2: assert property (@(posedge clk) disable iff (rst)
    out_vld && !out_ovf |-> out_cosh > (out_sinh[OUT_W-1] ? -out_sinh : out_sinh));

  // R6: overflowed results are saturated
  p_ovf_saturates_r6: assert property (@(posedge clk) disable iff (rst)
    out_vld && out_ovf |-> out_cosh == MAXV && (out_sinh == MAXV || out_sinh == -MAXV));

  if (EXP_EN != 0) begin : g_exp_chk
    // R5: exponential is the signed sum of the two outputs
    p_exp_is_sum_r5: assert property (@(posedge clk) disable iff (rst)
      out_vld && !out_ovf |-> out_exp == out_cosh + out_sinh);
  end

endmodule

// File: rtl/hyp_sinhcosh_exp.sv
module hyp_sinhcosh_exp #(
  parameter int IN_W     = 16,
  parameter int IN_FRAC  = 10,
  parameter int INT_MAX  = 4,
  parameter int ITERS    = 16,
  parameter int CORD_W   = 26,
  parameter int CORD_F   = 22,
  parameter int OUT_W    = 28,
  parameter int OUT_FRAC = 16,
  parameter int EXP_EN   = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_x,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_cosh,
  output logic signed [OUT_W-1:0] out_sinh,
  output logic signed [OUT_W-1:0] out_exp,
  output logic                    out_ovf
);
  localparam int DEPTH = INT_MAX + 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic signed [CORD_W-1:0] XINIT =
    CORD_W'(hyp_pkg::to_fix(hyp_pkg::inv_gain(ITERS), CORD_F));

  logic                    en;
  logic                    r_vld;
  logic                    r_neg;
  logic                    r_ovf;
  logic [IDX_W-1:0]        r_idx;
  logic [IN_FRAC-1:0]      r_frac;

  logic                    cv [ITERS+1];
  logic                    cn [ITERS+1];
  logic                    co [ITERS+1];
  logic [IDX_W-1:0]        ci [ITERS+1];
  logic signed [CORD_W-1:0] cx [ITERS+1];
  logic signed [CORD_W-1:0] cy [ITERS+1];
  logic signed [CORD_W-1:0] cz [ITERS+1];

  logic                    m_vld;
  logic                    m_neg;
  logic                    m_ovf;
  logic signed [CORD_W-1:0] m_cc;
  logic signed [CORD_W-1:0] m_cs;
  logic signed [OUT_W-1:0] t_ch;
  logic signed [OUT_W-1:0] t_sh;

  // Whole pipeline advances unless a finished result is waiting
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  hyp_reduce #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .INT_MAX(INT_MAX), .IDX_W(IDX_W)
  ) u_reduce (
    .clk(clk), .rst(rst), .en(en), .in_vld(in_valid), .in_x(in_x),
    .vld_q(r_vld), .neg_q(r_neg), .ovf_q(r_ovf), .idx_q(r_idx), .frac_q(r_frac)
  );

  assign cv[0] = r_vld;
  assign cn[0] = r_neg;
  assign co[0] = r_ovf;
  assign ci[0] = r_idx;
  assign cx[0] = XINIT;
  assign cy[0] = '0;
  assign cz[0] = CORD_W'({r_frac, {(CORD_F - IN_FRAC){1'b0}}});

  for (genvar k = 0; k < ITERS; k++) begin : g_rot
    hyp_cordic_stage #(
      .W(CORD_W), .FB(CORD_F), .STEP(k), .IDX_W(IDX_W)
    ) u_stage (
      .clk(clk), .rst(rst), .en(en),
      .in_vld(cv[k]), .in_neg(cn[k]), .in_ovf(co[k]), .in_idx(ci[k]),
      .x_i(cx[k]), .y_i(cy[k]), .z_i(cz[k]),
      .vld_q(cv[k+1]), .neg_q(cn[k+1]), .ovf_q(co[k+1]), .idx_q(ci[k+1]),
      .x_q(cx[k+1]), .y_q(cy[k+1]), .z_q(cz[k+1])
    );
  end

  hyp_int_rom #(
    .DEPTH(DEPTH), .W(OUT_W), .FB(OUT_FRAC), .AW(IDX_W)
  ) u_rom (
    .clk(clk), .en(en), .addr(ci[ITERS]), .ch_q(t_ch), .sh_q(t_sh)
  );

  // Align rotator results with the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      m_vld <= 1'b0;
    end else if (en) begin
      m_vld <= cv[ITERS];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      m_neg <= cn[ITERS];
      m_ovf <= co[ITERS];
      m_cc  <= cx[ITERS];
      m_cs  <= cy[ITERS];
    end
  end

  hyp_combine #(
    .OUT_W(OUT_W), .CW(CORD_W), .CF(CORD_F), .EXP_EN(EXP_EN)
  ) u_combine (
    .clk(clk), .rst(rst), .en(en),
    .in_vld(m_vld), .in_neg(m_neg), .in_ovf(m_ovf),
    .rc(t_ch), .rs(t_sh), .cc(m_cc), .cs(m_cs),
    .out_vld(out_valid), .out_ovf(out_ovf),
    .out_cosh(out_cosh), .out_sinh(out_sinh), .out_exp(out_exp)
  );

  // R8: a stalled result stays put until taken
  p_hold_when_stalled_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_cosh) &&
      $stable(out_sinh) && $stable(out_exp) && $stable(out_ovf));

endmodule

// File: tb/hyp_sinhcosh_exp_test.sv
`timescale 1ns/1ps
module hyp_sinhcosh_exp_test;
  localparam int  NMAX  = 16384;
  localparam real ISC   = 1024.0;
  localparam real OSC   = 65536.0;
  localparam longint MAXV = 134217727;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_x = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [27:0] out_cosh;
  logic signed [27:0] out_sinh;
  logic signed [27:0] out_exp;
  logic out_ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int stim [NMAX];
  int ns = 0;
  longint prev_c = 0;
  longint prev_s = 0;

  always #2 clk = ~clk;

  hyp_sinhcosh_exp uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x),
    .out_valid(out_valid), .out_ready(out_ready), .out_cosh(out_cosh),
    .out_sinh(out_sinh), .out_exp(out_exp), .out_ovf(out_ovf)
  );

  task automatic chk_int(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_tol(input string req, input real act, input real exp, input real tol);
    real d;
    n_cmp++;
    d = act - exp;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s actual=%f expected=%f", req, act, exp);
    end
  endtask

  task automatic add_stim(input int v);
    stim[ns] = v;
    ns++;
  endtask

  task automatic check_result(input int r);
    int  x;
    int  mag;
    int  ip;
    bit  eo;
    real xr;
    real ec;
    real tol;
    x   = stim[r];
    mag = (x < 0) ? -x : x;
    ip  = mag / 1024;
    eo  = ip > 4;
    xr  = real'(x) / ISC;
    if (ip == 4 || ip == 5) chk_int("R7", longint'(out_ovf), longint'(eo));
    else                    chk_int("R6", longint'(out_ovf), longint'(eo));
    if (eo) begin
      chk_int("R6", out_cosh, MAXV);
      chk_int("R6", out_sinh, (x < 0) ? -MAXV : MAXV);
      chk_int("R6", out_exp, (x < 0) ? 0 : MAXV);
    end else begin
      ec  = $cosh(xr);
      tol = ec * 1.0e-3 + 16.0 / OSC;
      chk_tol("R2", real'(out_cosh) / OSC, ec, tol);
      chk_tol("R3", real'(out_sinh) / OSC, $sinh(xr), tol);
      chk_tol("R5", real'(out_exp) / OSC, $exp(xr), tol);
      chk_int("R5", out_exp, longint'(out_cosh) + longint'(out_sinh));
    end
    // R4: mirrored partner of the previous sample
    if (r > 0 && x < 0 && x == -stim[r-1]) begin
      chk_int("R4", out_cosh, prev_c);
      chk_int("R4", out_sinh, -prev_s);
    end
    prev_c = out_cosh;
    prev_s = out_sinh;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int si;
    int ri;
    int cyc;
    int cnt;
    bit in_fire;
    bit hold;
    longint hc;
    longint hs;
    longint he;

    // stimulus: boundaries, then a strided sweep in mirrored pairs
    add_stim(0);
    add_stim(4096);  add_stim(-4096);
    add_stim(5119);  add_stim(-5119);
    add_stim(5120);  add_stim(-5120);
    add_stim(1);     add_stim(-1);
    add_stim(32767); add_stim(-32767);
    add_stim(-32768);
    for (int v = 3; v <= 32767; v += 5) begin
      add_stim(v);
      add_stim(-v);
    end

    repeat (4) @(posedge clk);
    #1;
    chk_int("R1", longint'(out_valid), 0);
    chk_int("R1", longint'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk_int("R1", longint'(out_valid), 0);
    chk_int("R1", longint'(in_ready), 1);

    // R9: latency of one isolated sample at full throughput
    in_x = 16'sd1536;
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    cnt = 0;
    while (!out_valid && cnt < 100) begin
      @(posedge clk);
      #1;
      cnt++;
    end
    chk_int("R9", cnt, 19);
    chk_tol("R9", real'(out_cosh) / OSC, $cosh(1.5), 0.01);
    @(posedge clk);
    #1;
    chk_int("R9", longint'(out_valid), 0);

    // main sweep with a throttled output
    si = 0;
    ri = 0;
    cyc = 0;
    in_fire = 1'b0;
    hold = 1'b0;
    hc = 0; hs = 0; he = 0;
    while (ri < ns) begin
      @(negedge clk);
      if (in_fire) si++;
      out_ready = (cyc % 4) != 3;
      in_valid  = (si < ns) && ((cyc % 7) != 6);
      in_x      = (si < ns) ? 16'(stim[si]) : '0;
      #1;
      in_fire = in_valid && in_ready;
      if (hold) begin
        chk_int("R8", longint'(out_valid), 1);
        chk_int("R8", out_cosh, hc);
        chk_int("R8", out_sinh, hs);
        chk_int("R8", out_exp, he);
      end
      chk_int("R8", longint'(in_ready), longint'(!out_valid || out_ready));
      hold = out_valid && !out_ready;
      hc = out_cosh;
      hs = out_sinh;
      he = out_exp;
      if (out_valid && out_ready) begin
        check_result(ri);
        ri++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule